// File: doc/BRIEF.md
# Modem Line Status Tracker

This block keeps the modem status byte of a 16550-style serial port. Four modem input lines arrive already synchronized: clear-to-send, data-set-ready, ring indicator and carrier detect. Each clock the block samples them into a level register and compares the new sample with the previous one. A difference raises a change flag for that line. The flags stay set until the host reads the byte. The ring line flags only its rising edge.

While the enable bit from the interrupt enable register is high and any change flag is set, the block drives a registered modem-status interrupt request. The surrounding priority logic gives this request the lowest rank. In loopback mode the four modem-control outputs take the place of the pins as the sampled sources, so software can exercise the status path without any external wiring.

Top module: `modem_status_unit`

## Requirements
- R1: The status byte holds the change flags in bits 3..0 (bit 0 CTS change, bit 1 DSR change, bit 2 ring rising edge, bit 3 DCD change) and the sampled levels in bits 7..4 (bit 4 CTS, bit 5 DSR, bit 6 RI, bit 7 DCD). On `line_in`, bit 0 is CTS, bit 1 DSR, bit 2 RI and bit 3 DCD.
- R2: While reset is asserted, the status byte is 0x00 and the interrupt request is low.
- R3: The first clock after reset loads the line levels into bits 7..4 and sets no change flag, whatever the levels are.
- R4: After reset, a change on CTS, DSR or DCD in either direction sets that line's change flag at the next clock edge.
- R5: The ring flag sets only when the sampled RI goes from 0 to 1. A 1 to 0 change of RI sets no flag.
- R6: Change flags are sticky. Further transitions of a flagged line, and transitions on other lines, never clear a set flag.
- R7: A cycle with `rd_stb` high presents the flags as they stood before the read, and clears them at that clock edge.
- R8: If a line changes in the same cycle as a read, the read shows the old flags and the new flag is set after the read.
- R9: `irq_q` is registered. After each clock edge it equals `intr_en` ANDed with the OR of the change flags that the same edge produced.
- R10: When `mctl[4]` (loop) is 1, the pins are ignored and the sources are: CTS from `mctl[1]` (RTS), DSR from `mctl[0]` (DTR), RI from `mctl[2]` (OUT1), DCD from `mctl[3]` (OUT2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 4 | Synchronized modem lines: CTS, DSR, RI, DCD (bit 0 to bit 3) |
| mctl | input | 5 | Modem control: DTR, RTS, OUT1, OUT2, loop (bit 0 to bit 4) |
| intr_en | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | Host read of the status byte; clears the change flags |
| status_q | output | 8 | Status byte: levels in the upper nibble, change flags in the lower nibble |
| irq_q | output | 1 | Registered modem-status interrupt request |

## Verification
The hardest case is a read that lands in the same cycle as a new line change. The returned byte must show only the old flags, and the new flag must still be set after the clear. The bench reaches this case by driving a line transition and the read strobe at the same falling edge. It compares the byte before the clock edge and again after it. A ring line that falls while other flags are pending, and pin activity during loopback, are also driven on purpose. In both cases a wrong design would visibly disturb the flags.

// File: rtl/msu_pkg.sv
package msu_pkg;
  localparam int NLINES = 4;
  localparam int STW    = 2 * NLINES;
  localparam int MCW    = 5;

  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_OUT1 = 2;
  localparam int MC_OUT2 = 3;
  localparam int MC_LOOP = 4;

  // Loopback wiring: control outputs mapped onto the line positions
  function automatic logic [NLINES-1:0] loop_feed(input logic [MCW-1:0] m);
    logic [NLINES-1:0] r;
    r        = '0;
    r[L_CTS] = m[MC_RTS];
    r[L_DSR] = m[MC_DTR];
    r[L_RI]  = m[MC_OUT1];
    r[L_DCD] = m[MC_OUT2];
    return r;
  endfunction

  // Change rule for one line: any toggle, or rising edge only
  function automatic logic line_event(input logic prev, input logic cur,
                                      input logic rise_only);
    return rise_only ? (cur & ~prev) : (cur ^ prev);
  endfunction
endpackage

// File: rtl/msu_source_sel.sv
module msu_source_sel
  import msu_pkg::*;
(
  input  logic [NLINES-1:0] line_in,
  input  logic [MCW-1:0]    mctl,
  output logic [NLINES-1:0] src
);
  assign src = mctl[MC_LOOP] ? loop_feed(mctl) : line_in;
endmodule

// File: rtl/msu_edge_det.sv
module msu_edge_det
  import msu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] src,
  output logic [NLINES-1:0] level_q,
  output logic [NLINES-1:0] ev,
  output logic              primed_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q  <= '0;
      primed_q <= 1'b0;
    end else begin
      level_q  <= src;
      primed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    localparam logic RISE_ONLY = (i == L_RI);
    assign ev[i] = primed_q & line_event(level_q[i], src[i], RISE_ONLY);
  end

  // R5
  ri_fall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q[L_RI] && !src[L_RI]) |-> !ev[L_RI]);
endmodule

// File: rtl/msu_flag_bank.sv
module msu_flag_bank
  import msu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] ev,
  input  logic              rd_stb,
  output logic [NLINES-1:0] delta_q,
  output logic [NLINES-1:0] delta_nxt
);
  assign delta_nxt = (rd_stb ? '0 : delta_q) | ev;

  always_ff @(posedge clk) begin
    if (!rst_n) delta_q <= '0;
    else        delta_q <= delta_nxt;
  end

  // R6
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && ev == '0) |=> (delta_q == '0));
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_in,
  input  logic [MCW-1:0]    mctl,
  input  logic              intr_en,
  input  logic              rd_stb,
  output logic [STW-1:0]    status_q,
  output logic              irq_q
);
  logic [NLINES-1:0] src, level_q, ev, delta_q, delta_nxt;
  logic              primed_q;

  msu_source_sel u_src (
    .line_in (line_in),
    .mctl    (mctl),
    .src     (src)
  );

  msu_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src),
    .level_q  (level_q),
    .ev       (ev),
    .primed_q (primed_q)
  );

  msu_flag_bank u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .rd_stb    (rd_stb),
    .delta_q   (delta_q),
    .delta_nxt (delta_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= intr_en & (|delta_nxt);
  end

  assign status_q = {level_q, delta_q};

  // R9
  irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (|status_q[NLINES-1:0]));

  // R9
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(intr_en));

  // R3
  no_flag_unprimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |-> (status_q[NLINES-1:0] == '0));
endmodule

// File: tb/modem_status_unit_tb.sv
module modem_status_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] line_in = 4'hF;
  logic [4:0] mctl = 5'h0;
  logic       intr_en = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] status_q;
  logic       irq_q;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] st;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  // bench-side reference state
  logic [3:0] m_lvl = '0;
  logic [3:0] m_flg = '0;
  bit         m_primed = 0;

  always #4 clk = ~clk;

  modem_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .mctl(mctl),
    .intr_en(intr_en), .rd_stb(rd_stb), .status_q(status_q), .irq_q(irq_q)
  );

  task automatic check(input string tag, input logic [7:0] st, input logic irq,
                       input logic [7:0] est, input logic eirq);
    checks++;
    if (st !== est || irq !== eirq) begin
      errors++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               tag, st, irq, est, eirq);
    end
  endtask

  // monitor: compare one expected item per falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, status_q, irq_q, e.st, e.irq);
    end
  end

  task automatic step(input logic [3:0] pins, input logic [4:0] mc,
                      input logic en, input logic rd, input string tag);
    logic [3:0] s, ev, nf;
    exp_t e;
    @(negedge clk);
    #1;
    line_in = pins; mctl = mc; intr_en = en; rd_stb = rd;
    if (rd) begin
      #1;
      check({tag, " read value"}, status_q, irq_q, {m_lvl, m_flg}, irq_q);
    end
    s = mc[4] ? {mc[3], mc[2], mc[0], mc[1]} : pins;
    ev = '0;
    if (m_primed) ev = ((s ^ m_lvl) & 4'b1011) | (s & ~m_lvl & 4'b0100);
    nf = (rd ? 4'b0 : m_flg) | ev;
    m_flg = nf; m_lvl = s; m_primed = 1;
    e.st = {s, nf}; e.irq = en & (|nf); e.tag = tag;
    @(posedge clk);
    sb_q.push_back(e);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset", status_q, irq_q, 8'h00, 1'b0);
    #1 rst_n = 1'b1;
    // R3, R1: levels load, no flags
    step(4'b1111, 5'h00, 1, 0, "R3 prime");
    // R4, R9: CTS falls
    step(4'b1110, 5'h00, 1, 0, "R4 cts fall");
    // R5, R6: RI falls, no new flag, CTS flag kept
    step(4'b1010, 5'h00, 1, 0, "R5 ri fall");
    // R7: read then cleared
    step(4'b1010, 5'h00, 1, 1, "R7 read");
    // R5: RI rises
    step(4'b1110, 5'h00, 1, 0, "R5 ri rise");
    // R4: DSR fall, DCD fall, DCD rise (R6 sticky)
    step(4'b1100, 5'h00, 1, 0, "R4 dsr fall");
    step(4'b0100, 5'h00, 1, 0, "R4 dcd fall");
    step(4'b1100, 5'h00, 1, 0, "R6 dcd again");
    // R8: CTS rises during read
    step(4'b1101, 5'h00, 1, 1, "R8 read+change");
    step(4'b1101, 5'h00, 1, 0, "R8 kept");
    // R9: disable with pending flag
    step(4'b1101, 5'h00, 0, 0, "R9 disabled");
    step(4'b1101, 5'h00, 1, 0, "R9 reenabled");
    step(4'b1101, 5'h00, 1, 1, "R7 clear");
    step(4'b1101, 5'h00, 1, 0, "R7 quiet");
    // R10: loopback with RTS only
    step(4'b0000, 5'b10010, 1, 0, "R10 loop enter");
    step(4'b1111, 5'b10010, 1, 1, "R10 pins ignored read");
    step(4'b0000, 5'b10010, 1, 0, "R10 pins ignored");
    step(4'b0000, 5'b10110, 1, 0, "R10 out1 to ri");
    step(4'b0000, 5'b11111, 1, 1, "R10 dtr out2");
    step(4'b0000, 5'b11111, 1, 0, "R10 settle");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule